// File: doc/BRIEF.md
# Pulse-Echo Burst Timing Sequencer

This block produces the repeating timing frame that drives an ultrasound transmit/receive front end, all from one system clock. Each frame is one period of a square repetition signal: a high half followed by a low half of equal length. The transmit burst is placed backwards from the end of the low half, so its last carrier period finishes on the final cycle before the repetition signal rises again. Its start therefore moves earlier as the pulse count grows.

Three more outputs travel with the repetition signal. The first is an envelope that is high for the whole burst. The second is a one-cycle strobe that marks the first cycle of every carrier period, so an external complementary driver can phase-lock to it. The third is a receive window with the same length as the envelope, whose rising edge lags the envelope's rising edge by a programmable number of cycles. That delay sets the echo sample depth, and the window may run on into the next frame's high half.

The pulse count and the receive delay are taken once per frame, on the last cycle of the high half. Changes at any other time never disturb a frame that is already running.

Top module: `echo_burst_sequencer`

## Requirements
- R1: While rst_ni is low, all four outputs are low, and they go low at once when reset is asserted. After release, prf_o is high on the first HALF_CYC clock cycles.
- R2: prf_o repeats with a period of 2*HALF_CYC cycles: HALF_CYC cycles high, then HALF_CYC cycles low.
- R3: pulse_o is high for exactly CARRIER_CYC*n consecutive cycles, all within the low half of prf_o. Its last high cycle is the last low cycle of prf_o, where n is the pulse count taken for that frame.
- R4: burst_en_o is high for one cycle at the start of each CARRIER_CYC-cycle carrier period inside the burst. That gives n strobes per frame, and the first one coincides with the rising edge of pulse_o.
- R5: A pulse_count_i value of 0 is treated as 1, and a value above MAX_PULSES is treated as MAX_PULSES.
- R6: gate_o is high for the same number of cycles as pulse_o. Its rising edge comes exactly D cycles after the rising edge of pulse_o, where D is the delay taken for that frame. With D = 0 the two signals coincide.
- R7: When the receive window crosses the rising edge of prf_o, it continues into the next frame's high half without being cut short.
- R8: A gate_delay_i value above 2*HALF_CYC - CARRIER_CYC*MAX_PULSES is treated as that limit.
- R9: pulse_count_i and gate_delay_i are sampled only on the last high cycle of prf_o. A change made at any other time has no effect on the burst or window of the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_count_i | input | CNT_W | Carrier periods per burst |
| gate_delay_i | input | DLY_W | Receive window delay in clock cycles |
| prf_o | output | 1 | Repetition square wave |
| pulse_o | output | 1 | Transmit burst envelope |
| burst_en_o | output | 1 | One-cycle strobe per carrier period |
| gate_o | output | 1 | Receive window |

## Verification
On every cycle, the assertions check that the burst envelope stays inside the low half and falls on the very edge where the repetition signal rises. They also check that strobes occur only inside the burst and never on two cycles in a row, that the latched count stays within range and changes only at the sampling point, and that one receive window never overlaps the next burst start. The exact placement of each burst for a given count is shown only by the bench scenarios. So are the delay of the window, its crossing into the next frame, the clamping of both settings, and immunity to changes made in the middle of a frame. The bench compares every cycle against its own timeline model.

// File: rtl/echo_seq_pkg.sv
package echo_seq_pkg;

  function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/seq_frame_timer.sv
module seq_frame_timer #(
  parameter int unsigned HALF_CYC = 1000,
  parameter int unsigned PW       = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] pos_o,
  output logic          latch_o,
  output logic          high_o
);
  localparam int unsigned PERIOD = 2 * HALF_CYC;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pos_q <= '0;
    else if (pos_q == LAST) pos_q <= '0;
    else                    pos_q <= pos_q + 1'b1;
  end

  assign pos_o   = pos_q;
  assign latch_o = (pos_q == PW'(HALF_CYC - 1));
  assign high_o  = (pos_q < PW'(HALF_CYC));

  // R2
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < PW'(PERIOD));

  // R2
  pos_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == LAST) |=> (pos_q == '0));

endmodule

// File: rtl/seq_burst_window.sv
module seq_burst_window #(
  parameter int unsigned HALF_CYC    = 1000,
  parameter int unsigned CARRIER_CYC = 4,
  parameter int unsigned MAX_PULSES  = 10,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned PW          = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PW-1:0]    pos_i,
  input  logic             latch_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             pulse_o,
  output logic             strobe_o,
  output logic             start_o,
  output logic [PW-1:0]    len_o
);
  localparam logic [PW-1:0] HALF_P = PW'(HALF_CYC);
  localparam logic [PW-1:0] CAR_P  = PW'(CARRIER_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    len, lp, first, rem;
  logic             low, live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (latch_i) cnt_q <= count_i;
  end

  // burst is anchored to the end of the low half
  always_comb begin
    len   = CAR_P * PW'(cnt_q);
    low   = (pos_i >= HALF_P);
    lp    = pos_i - HALF_P;
    first = HALF_P - len;
    live  = low && (cnt_q != '0);
    rem   = (HALF_P - 1'b1) - lp;
  end

  assign pulse_o  = live && (lp >= first);
  assign start_o  = live && (lp == first);
  assign strobe_o = pulse_o && ((rem % CAR_P) == (CAR_P - 1'b1));
  assign len_o    = len;

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(cnt_q));

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (cnt_q != '0) && (cnt_q <= CNT_W'(MAX_PULSES)));

endmodule

// File: rtl/seq_gate_timer.sv
module seq_gate_timer #(
  parameter int unsigned PERIOD = 2000,
  parameter int unsigned PW     = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic [PW-1:0] delay_i,
  input  logic          start_i,
  input  logic [PW-1:0] len_i,
  output logic          gate_o
);
  logic          run_q;
  logic [PW-1:0] off_q, gd_q, gl_q, dly_q;
  logic [PW-1:0] off, d, l;
  logic [PW:0]   end_v, off_nx;
  logic          active;

  // window keeps its own copy of delay and length so the next latch cannot cut it
  always_comb begin
    off    = start_i ? '0 : off_q;
    d      = start_i ? dly_q : gd_q;
    l      = start_i ? len_i : gl_q;
    active = start_i || run_q;
    end_v  = {1'b0, d} + {1'b0, l};
    off_nx = {1'b0, off} + 1'b1;
  end

  assign gate_o = active && (off >= d) && ({1'b0, off} < end_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      off_q <= '0;
      gd_q  <= '0;
      gl_q  <= '0;
      dly_q <= '0;
    end else begin
      if (latch_i) dly_q <= delay_i;
      run_q <= active && (off_nx < end_v);
      off_q <= active ? off_nx[PW-1:0] : '0;
      if (start_i) begin
        gd_q <= dly_q;
        gl_q <= len_i;
      end
    end
  end

  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);

  // R7
  off_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (off_q < PW'(PERIOD)));

endmodule

// File: rtl/echo_burst_sequencer.sv
module echo_burst_sequencer
  import echo_seq_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 1000,
  parameter int unsigned CARRIER_CYC = 4,
  parameter int unsigned MAX_PULSES  = 10,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned DLY_W       = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] pulse_count_i,
  input  logic [DLY_W-1:0] gate_delay_i,
  output logic             prf_o,
  output logic             pulse_o,
  output logic             burst_en_o,
  output logic             gate_o
);
  localparam int unsigned PERIOD  = 2 * HALF_CYC;
  localparam int unsigned PW      = $clog2(PERIOD + 1);
  localparam int unsigned MAX_DLY = PERIOD - CARRIER_CYC * MAX_PULSES;

  logic [PW-1:0]    pos, len;
  logic             latch, high, pulse_n, strobe_n, start_n, gate_n;
  logic [CNT_W-1:0] cnt_cl;
  logic [PW-1:0]    dly_cl;

  assign cnt_cl = CNT_W'(clamp_u(32'(pulse_count_i), 1, MAX_PULSES));
  assign dly_cl = PW'(clamp_u(32'(gate_delay_i), 0, MAX_DLY));

  seq_frame_timer #(.HALF_CYC(HALF_CYC), .PW(PW)) i_frame (
    .clk_i, .rst_ni, .pos_o(pos), .latch_o(latch), .high_o(high)
  );

  seq_burst_window #(
    .HALF_CYC(HALF_CYC), .CARRIER_CYC(CARRIER_CYC), .MAX_PULSES(MAX_PULSES),
    .CNT_W(CNT_W), .PW(PW)
  ) i_burst (
    .clk_i, .rst_ni, .pos_i(pos), .latch_i(latch), .count_i(cnt_cl),
    .pulse_o(pulse_n), .strobe_o(strobe_n), .start_o(start_n), .len_o(len)
  );

  seq_gate_timer #(.PERIOD(PERIOD), .PW(PW)) i_gate (
    .clk_i, .rst_ni, .latch_i(latch), .delay_i(dly_cl),
    .start_i(start_n), .len_i(len), .gate_o(gate_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prf_o      <= 1'b0;
      pulse_o    <= 1'b0;
      burst_en_o <= 1'b0;
      gate_o     <= 1'b0;
    end else begin
      prf_o      <= high;
      pulse_o    <= pulse_n;
      burst_en_o <= strobe_n;
      gate_o     <= gate_n;
    end
  end

  // R3
  burst_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> !prf_o);

  // R3
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> $rose(prf_o));

  // R4
  strobe_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_en_o |-> pulse_o);

  // R4
  strobe_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> burst_en_o);

  generate
    if (CARRIER_CYC > 1) begin : g_strobe_gap
      // R4
      strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burst_en_o |=> !burst_en_o);
    end
  endgenerate

endmodule

// File: tb/test_echo_burst_sequencer.sv
module test_echo_burst_sequencer;
  localparam int HALF = 1000;
  localparam int PER  = 2 * HALF;
  localparam int CAR  = 4;
  localparam int MAXP = 10;
  localparam int MAXD = PER - CAR * MAXP;

  typedef struct packed {
    logic [3:0]  cnt;
    logic [10:0] dly;
    logic [3:0]  exp_n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd10, 11'd390,  4'd10},
    '{4'd5,  11'd0,    4'd5},
    '{4'd7,  11'd1200, 4'd7},
    '{4'd1,  11'd1959, 4'd1},
    '{4'd0,  11'd50,   4'd1},
    '{4'd15, 11'd2047, 4'd10},
    '{4'd3,  11'd1700, 4'd3},
    '{4'd10, 11'd1960, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cnt_in = '0;
  logic [10:0] dly_in = '0;
  logic        prf, pulse, ben, gate;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench timeline model
  int k = 0, lc = 0, ld = 0, ks = 0, gd = 0, gc = 0;
  bit started = 0, prev_p = 0;
  int werr [4];
  int fk [4], fa [4], fe [4];
  int pulse_hi = 0, strobes = 0;

  always #4 clk = ~clk;

  echo_burst_sequencer i_echo_burst_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_count_i(cnt_in), .gate_delay_i(dly_in),
    .prf_o(prf), .pulse_o(pulse), .burst_en_o(ben), .gate_o(gate)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    k = 0; lc = 0; ld = 0; started = 0; prev_p = 0;
  endtask

  task automatic clear_win();
    for (int i = 0; i < 4; i++) begin werr[i] = 0; fk[i] = 0; fa[i] = 0; fe[i] = 0; end
    pulse_hi = 0; strobes = 0;
  endtask

  task automatic cmp(input int idx, input bit act, input bit exp);
    if (act !== exp) begin
      if (werr[idx] == 0) begin fk[idx] = k; fa[idx] = int'(act); fe[idx] = int'(exp); end
      werr[idx]++;
    end
  endtask

  task automatic step();
    int p;
    bit ep, epu, een, eg;
    @(negedge clk);
    k++;
    if (k % PER == HALF) begin
      lc = clampi(int'(cnt_in), 1, MAXP);
      ld = clampi(int'(dly_in), 0, MAXD);
    end
    p   = (k - 1) % PER;
    ep  = (p < HALF);
    epu = (p >= HALF) && (lc != 0) && (p >= PER - CAR * lc);
    een = epu && (((PER - 1 - p) % CAR) == CAR - 1);
    if (epu && !prev_p) begin ks = k; gd = ld; gc = lc; started = 1; end
    prev_p = epu;
    eg = started && (k - ks >= gd) && (k - ks < gd + CAR * gc);
    cmp(0, prf, ep);
    cmp(1, pulse, epu);
    cmp(2, ben, een);
    cmp(3, gate, eg);
    if (pulse) pulse_hi++;
    if (ben) strobes++;
  endtask

  task automatic report_win(input string tag);
    check(werr[0] == 0, $sformatf("R2 prf %s cycle %0d", tag, fk[0]), fa[0], fe[0]);
    check(werr[1] == 0, $sformatf("R3 R5 pulse %s cycle %0d", tag, fk[1]), fa[1], fe[1]);
    check(werr[2] == 0, $sformatf("R4 burst_en %s cycle %0d", tag, fk[2]), fa[2], fe[2]);
    check(werr[3] == 0, $sformatf("R6 R7 R8 gate %s cycle %0d", tag, fk[3]), fa[3], fe[3]);
  endtask

  initial begin
    int w;
    w = 0;
    while (!done) begin
      @(posedge clk);
      w++;
      if (w > 200000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", w, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    clear_win();
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    check({prf, pulse, ben, gate} == 4'b0, "R1 outputs in reset", int'({prf, pulse, ben, gate}), 0);
    cnt_in = VECS[0].cnt;
    dly_in = VECS[0].dly;
    rst_ni = 1'b1;
    model_reset();
    step();
    check(prf == 1'b1, "R1 prf high on first cycle", int'(prf), 1);

    for (int v = 0; v < NV; v++) begin
      if (v != 0) begin
        cnt_in = VECS[v].cnt;
        dly_in = VECS[v].dly;
      end
      clear_win();
      repeat (PER - ((v == 0) ? 1 : 0)) step();
      report_win($sformatf("vec%0d", v));
      // R3 R5: burst length in this frame
      check(pulse_hi == CAR * int'(VECS[v].exp_n), $sformatf("R3 R5 pulse length vec%0d", v),
            pulse_hi, CAR * int'(VECS[v].exp_n));
      // R4: strobes per burst
      check(strobes == int'(VECS[v].exp_n), $sformatf("R4 strobe count vec%0d", v),
            strobes, int'(VECS[v].exp_n));
    end

    // R9: mid-frame change must not touch the running frame
    cnt_in = 4'd4; dly_in = 11'd30;
    clear_win();
    repeat (1500) step();
    cnt_in = 4'd10; dly_in = 11'd0;
    repeat (500) step();
    report_win("R9 mid-frame change");
    check(pulse_hi == 16, "R9 pulse length after late change", pulse_hi, 16);
    clear_win();
    repeat (PER) step();
    report_win("R9 next frame");
    check(pulse_hi == 40, "R9 new count taken next frame", pulse_hi, 40);

    // R1: reset in the middle of a burst, then restart
    cnt_in = 4'd6; dly_in = 11'd5;
    clear_win();
    repeat (1990) step();
    rst_ni = 1'b0;
    #1;
    check({prf, pulse, ben, gate} == 4'b0, "R1 outputs on async reset", int'({prf, pulse, ben, gate}), 0);
    @(negedge clk);
    model_reset();
    rst_ni = 1'b1;
    clear_win();
    step();
    check(prf == 1'b1, "R1 prf high after restart", int'(prf), 1);
    repeat (HALF - 1) step();
    check(prf == 1'b1, "R1 prf still high at cycle HALF", int'(prf), 1);
    step();
    check(prf == 1'b0, "R2 prf low at cycle HALF+1", int'(prf), 0);
    repeat (PER - HALF - 1) step();
    report_win("R1 restart");
    check(pulse_hi == 24, "R3 pulse length after restart", pulse_hi, 24);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule